// File: doc/BRIEF.md
# Byte String Move and Compare Engine

This block runs memory string operations on its own, through one synchronous memory port. A single start pulse loads three working registers: a destination pointer, a second operand that is either a source pointer or a fill value, and a count. The engine then walks memory, one byte or fill unit per step, until its termination rule is met. The rule depends on the operation: a count reaching zero, a copied zero byte, or a byte mismatch.

Five operations are supported. They are forward copy, backward copy, copy that ends on a zero byte, fill in 8-, 16- or 32-bit units, and unsigned byte-string compare. A compare reports its outcome on a zero flag and a carry flag. The final pointers and the remaining count stay visible on output ports. A cost output gives the cycle cost that the operation is charged, computed from the number of steps actually performed.

Top module: `strm_engine`

## Requirements
- R1: With op code 0 (forward copy), each step moves the byte at the source pointer to the destination pointer, adds one to both pointers and subtracts one from the count, until the count is zero. Read data is expected on `mem_rdata_i` in the cycle after a read request.
- R2: With op code 1 (backward copy), each step reads at the source pointer, writes that byte at the destination pointer, then subtracts one from both pointers and from the count, until the count is zero.
- R3: With op code 2 (copy until zero), the engine copies forward as in R1 but ends after the step that copied a zero byte, or when the count runs out, whichever comes first.
- R4: With op code 3 (fill), `unit_i` 0, 1 or 2 writes the low 1, 2 or 4 bytes of the fill value, little-endian, at the destination pointer. `mem_size_o` carries that same code. The pointer then advances by the unit size and the count drops by one per unit. The fill value does not change.
- R5: With op code 4 (compare), each step reads a first byte at the destination pointer and a second byte at the source pointer. It then adds one to both pointers and subtracts one from the count. The compare ends when the bytes differ, when the first byte is zero, or when the count is zero.
- R6: After a compare, `flag_z_o` is 1 exactly when the last two bytes compared were equal. `flag_c_o` is 1 exactly when the first byte is greater than or equal to the second, both taken as unsigned. Copy and fill operations leave both flags unchanged.
- R7: A start with a count of zero loads the registers but makes no memory request and never raises `busy_o`. A compare started this way leaves the flags unchanged.
- R8: `busy_o` is high from the clock edge that accepts a start until the edge of the terminating step. A start pulse while busy is ignored. No memory request is made while idle.
- R9: Once the engine is idle, `cost_o` reports the cost for n performed steps, where q = n/4 and r = n mod 4:
  - Forward copy and copy until zero: 2 + 3q + 3r.
  - Backward copy: 6 + 3q + 3r when n > 3, otherwise 2 + 3r.
  - Byte fill: 2 + q + r.
  - Halfword fill: 2 + n/2 + (n mod 2).
  - Word fill: 2 + n.
  - Compare: 2 + 4q + 4r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted while idle |
| op_i | input | 3 | Operation code (0 to 4) |
| unit_i | input | 2 | Fill unit code: 0 byte, 1 halfword, 2 word |
| dst_i | input | PW | Initial destination pointer |
| src_i | input | 32 | Initial source pointer or fill value |
| cnt_i | input | CW | Initial count |
| busy_o | output | 1 | Operation in progress |
| dst_o | output | PW | Current destination pointer |
| src_o | output | 32 | Current source pointer or fill value |
| cnt_o | output | CW | Current count |
| flag_z_o | output | 1 | Compare equal flag |
| flag_c_o | output | 1 | Compare first-not-below-second flag |
| cost_o | output | 32 | Cycle cost of the current or last operation |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the request |
| mem_size_o | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_addr_o | output | PW | Access byte address |
| mem_wdata_o | output | 32 | Write data, low bytes used |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |

## Verification
`busy_o` goes high at the first clock edge after start is sampled. The registers, the flags and `cost_o` are final at the edge where `busy_o` falls. The bench therefore samples on falling clock edges: its monitor pops the scoreboard entry at the first falling edge where `busy_o` reads low after having been high, and the memory image is compared one falling edge later. A zero-count start has no busy period, so its results are checked at the first falling edge after the start pulse, together with a count of memory requests that must not have moved.

// File: rtl/strm_pkg.sv
package strm_pkg;

  typedef enum logic [2:0] {
    OP_COPY_UP = 3'd0,
    OP_COPY_DN = 3'd1,
    OP_COPY_Z  = 3'd2,
    OP_FILL    = 3'd3,
    OP_CMP     = 3'd4
  } strm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WR, ST_FILL, ST_RDA, ST_RDB, ST_CMP
  } strm_st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic [2:0] unit_bytes(input logic [1:0] u);
    case (u)
      SZ_BYTE: unit_bytes = 3'd1;
      SZ_HALF: unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction

  // Cycle cost charged for n performed steps.
  function automatic logic [31:0] op_cost(input logic [2:0] op, input logic [1:0] u,
                                          input logic [31:0] n);
    logic [31:0] q4, r4;
    q4 = n >> 2;
    r4 = {30'd0, n[1:0]};
    case (op)
      OP_COPY_UP, OP_COPY_Z: op_cost = 32'd2 + 32'd3 * q4 + 32'd3 * r4;
      OP_COPY_DN: op_cost = (n > 32'd3) ? 32'd6 + 32'd3 * q4 + 32'd3 * r4
                                        : 32'd2 + 32'd3 * r4;
      OP_FILL: begin
        case (u)
          SZ_BYTE: op_cost = 32'd2 + q4 + r4;
          SZ_HALF: op_cost = 32'd2 + (n >> 1) + {31'd0, n[0]};
          default: op_cost = 32'd2 + n;
        endcase
      end
      OP_CMP:  op_cost = 32'd2 + 32'd4 * q4 + 32'd4 * r4;
      default: op_cost = 32'd2;
    endcase
  endfunction

endpackage

// File: rtl/strm_seq.sv
module strm_seq
  import strm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cnt_zero,
  input  logic       cnt_last,
  input  logic [2:0] op_new,
  input  logic [2:0] op_cur,
  input  logic [7:0] rd_byte,
  input  logic [7:0] held_byte,
  output strm_st_e   state,
  output logic       step,
  output logic       stop
);

  strm_st_e nxt;

  always_comb begin
    nxt  = state;
    step = 1'b0;
    stop = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start && !cnt_zero) begin
          case (op_new)
            OP_COPY_UP, OP_COPY_DN, OP_COPY_Z: nxt = ST_RD;
            OP_FILL:                           nxt = ST_FILL;
            OP_CMP:                            nxt = ST_RDA;
            default:                           nxt = ST_IDLE;
          endcase
        end
      end
      ST_RD: nxt = ST_WR;
      ST_WR: begin
        step = 1'b1;
        stop = cnt_last || (op_cur == OP_COPY_Z && rd_byte == 8'd0);
        nxt  = stop ? ST_IDLE : ST_RD;
      end
      ST_FILL: begin
        step = 1'b1;
        stop = cnt_last;
        nxt  = stop ? ST_IDLE : ST_FILL;
      end
      ST_RDA: nxt = ST_RDB;
      ST_RDB: nxt = ST_CMP;
      ST_CMP: begin
        step = 1'b1;
        stop = cnt_last || (held_byte != rd_byte) || (held_byte == 8'd0);
        nxt  = stop ? ST_IDLE : ST_RDA;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/strm_cost.sv
module strm_cost
  import strm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [2:0]    op,
  input  logic [1:0]    unit,
  input  logic [CW-1:0] steps,
  output logic [31:0]   cost
);

  always_comb cost = op_cost(op, unit, 32'(steps));

endmodule

// File: rtl/strm_engine.sv
module strm_engine
  import strm_pkg::*;
#(
  parameter int PW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op_i,
  input  logic [1:0]    unit_i,
  input  logic [PW-1:0] dst_i,
  input  logic [31:0]   src_i,
  input  logic [CW-1:0] cnt_i,
  output logic          busy_o,
  output logic [PW-1:0] dst_o,
  output logic [31:0]   src_o,
  output logic [CW-1:0] cnt_o,
  output logic          flag_z_o,
  output logic          flag_c_o,
  output logic [31:0]   cost_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [1:0]    mem_size_o,
  output logic [PW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i
);

  localparam logic [PW-1:0] P_ONE = PW'(1);
  localparam logic [CW-1:0] C_ONE = CW'(1);

  strm_st_e      state;
  logic [2:0]    op_q;
  logic [1:0]    unit_q;
  logic [PW-1:0] dst_q;
  logic [31:0]   src_q;
  logic [CW-1:0] cnt_q, steps_q;
  logic [7:0]    a_q;
  logic          z_q, c_q;

  // Named events
  logic       launch, step, stop, cnt_zero, cnt_last;
  logic [7:0] rd_byte;

  assign launch   = start && (state == ST_IDLE);
  assign cnt_zero = (cnt_i == '0);
  assign cnt_last = (cnt_q == C_ONE);
  assign rd_byte  = mem_rdata_i[7:0];

  strm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
    .op_new(op_i), .op_cur(op_q), .rd_byte(rd_byte), .held_byte(a_q),
    .state(state), .step(step), .stop(stop)
  );

  strm_cost #(.CW(CW)) u_cost (.op(op_q), .unit(unit_q), .steps(steps_q), .cost(cost_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0; unit_q <= '0; dst_q <= '0; src_q <= '0;
      cnt_q <= '0; steps_q <= '0; a_q <= '0; z_q <= 1'b0; c_q <= 1'b0;
    end else begin
      if (launch) begin
        op_q    <= op_i;
        unit_q  <= (unit_i == 2'd3) ? SZ_WORD : unit_i;
        dst_q   <= dst_i;
        src_q   <= src_i;
        cnt_q   <= cnt_i;
        steps_q <= '0;
      end
      if (state == ST_RDB) a_q <= rd_byte;
      if (step) begin
        cnt_q   <= cnt_q - C_ONE;
        steps_q <= steps_q + C_ONE;
        case (op_q)
          OP_COPY_DN: begin
            dst_q <= dst_q - P_ONE;
            src_q <= src_q - 32'd1;
          end
          OP_FILL: dst_q <= dst_q + PW'(unit_bytes(unit_q));
          default: begin
            dst_q <= dst_q + P_ONE;
            src_q <= src_q + 32'd1;
          end
        endcase
        if (op_q == OP_CMP) begin
          z_q <= (a_q == rd_byte);
          c_q <= (a_q >= rd_byte);
        end
      end
    end
  end

  always_comb begin
    busy_o      = (state != ST_IDLE);
    mem_req_o   = state inside {ST_RD, ST_WR, ST_FILL, ST_RDA, ST_RDB};
    mem_we_o    = state inside {ST_WR, ST_FILL};
    mem_addr_o  = (state == ST_RD || state == ST_RDB) ? src_q[PW-1:0] : dst_q;
    mem_size_o  = (state == ST_FILL) ? unit_q : SZ_BYTE;
    mem_wdata_o = (state == ST_FILL) ? src_q : {24'd0, rd_byte};
    dst_o       = dst_q;
    src_o       = src_q;
    cnt_o       = cnt_q;
    flag_z_o    = z_q;
    flag_c_o    = c_q;
  end

  // R1: forward copy advances both pointers and consumes one count
  a_r1_fwd_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op_q == OP_COPY_UP) |=> (dst_q == $past(dst_q) + P_ONE)
      && (src_q == $past(src_q) + 32'd1) && (cnt_q == $past(cnt_q) - C_ONE));

  // R2: backward copy retreats both pointers
  a_r2_back_retreat: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op_q == OP_COPY_DN) |=> (dst_q == $past(dst_q) - P_ONE)
      && (src_q == $past(src_q) - 32'd1));

  // R3: a copied zero byte ends copy-until-zero
  a_r3_zero_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR && op_q == OP_COPY_Z && rd_byte == 8'd0) |=> !busy_o);

  // R4: fill writes with the latched unit size
  a_r4_fill_size: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) |-> (mem_we_o && mem_size_o == unit_q));

  // R5: a byte mismatch ends the compare
  a_r5_mismatch_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMP && a_q != rd_byte) |=> !busy_o);

  // R6: flags move only on a compare step
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_CMP) |=> ($stable(flag_z_o) && $stable(flag_c_o)));

  // R7: zero count starts no activity
  a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cnt_zero) |=> (!busy_o && !mem_req_o));

  // R8: idle means no memory traffic; a terminating step drops busy
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy_o);

endmodule

// File: tb/test_strm_engine.sv
`timescale 1ns/1ps
module test_strm_engine;

  localparam logic [2:0] C_FWD = 3'd0, C_BACK = 3'd1, C_ZERO = 3'd2, C_FILL = 3'd3, C_CMP = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  unit_i = '0;
  logic [31:0] dst_i = '0, src_i = '0;
  logic [15:0] cnt_i = '0;
  logic        busy_o, flag_z_o, flag_c_o, mem_req_o, mem_we_o;
  logic [31:0] dst_o, src_o, cost_o, mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic [15:0] cnt_o;
  logic [1:0]  mem_size_o;

  always #2.5 clk = ~clk;

  strm_engine i_strm_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .unit_i(unit_i),
    .dst_i(dst_i), .src_i(src_i), .cnt_i(cnt_i), .busy_o(busy_o),
    .dst_o(dst_o), .src_o(src_o), .cnt_o(cnt_o), .flag_z_o(flag_z_o),
    .flag_c_o(flag_c_o), .cost_o(cost_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_size_o(mem_size_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  // Memory with one cycle read latency (R1), sizes 0/1/2 (R4)
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int         acc_cnt = 0;

  always @(posedge clk) begin
    if (mem_req_o) acc_cnt = acc_cnt + 1;
    if (mem_req_o && mem_we_o) begin
      mem[mem_addr_o[7:0]] = mem_wdata_o[7:0];
      if (mem_size_o != 2'd0) mem[8'(mem_addr_o[7:0] + 8'd1)] = mem_wdata_o[15:8];
      if (mem_size_o == 2'd2) begin
        mem[8'(mem_addr_o[7:0] + 8'd2)] = mem_wdata_o[23:16];
        mem[8'(mem_addr_o[7:0] + 8'd3)] = mem_wdata_o[31:24];
      end
    end else if (mem_req_o) begin
      mem_rdata_i <= {mem[8'(mem_addr_o[7:0] + 8'd3)], mem[8'(mem_addr_o[7:0] + 8'd2)],
                      mem[8'(mem_addr_o[7:0] + 8'd1)], mem[mem_addr_o[7:0]]};
    end
  end

  int errors = 0;
  int checks = 0;
  logic exp_z = 1'b0, exp_c = 1'b0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct {
    logic [31:0] dst;
    logic [31:0] src;
    logic [15:0] cnt;
    logic        z;
    logic        c;
    logic [31:0] cost;
  } exp_t;
  exp_t  sb_q[$];
  string tag_q[$];

  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (prev_busy && !busy_o) begin
      if (sb_q.size() == 0) begin
        chk("R8 completion without pending operation", 32'd1, 32'd0);
      end else begin
        exp_t  e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " dst"}, dst_o, e.dst);
        chk({t, " src"}, src_o, e.src);
        chk({t, " cnt"}, 32'(cnt_o), 32'(e.cnt));
        chk({t, " zero flag (R6)"}, 32'(flag_z_o), 32'(e.z));
        chk({t, " carry flag (R6)"}, 32'(flag_c_o), 32'(e.c));
        chk({t, " cost (R9)"}, cost_o, e.cost);
      end
    end
    prev_busy = busy_o;
  end

  function automatic int unit_len(input logic [1:0] u);
    return (u == 2'd0) ? 1 : (u == 2'd1) ? 2 : 4;
  endfunction

  // Reference model on ref_mem, built from the requirement text
  task automatic model(input logic [2:0] op, input logic [1:0] u, input logic [31:0] d0,
                       input logic [31:0] s0, input logic [15:0] n0, output exp_t e);
    logic [31:0] d, s;
    int          n, st, k;
    logic [7:0]  a, b;
    d = d0; s = s0; n = int'(n0); st = 0;
    while (n != 0) begin
      if (op == C_FILL) begin
        k = unit_len(u);
        for (int j = 0; j < k; j++) ref_mem[8'(d[7:0] + 8'(j))] = s[8*j +: 8];
        d = d + 32'(k);
        n--; st++;
      end else if (op == C_CMP) begin
        a = ref_mem[d[7:0]]; b = ref_mem[s[7:0]];
        d++; s++; n--; st++;
        exp_z = (a == b);
        exp_c = (a >= b);
        if (a != b || a == 8'd0) break;
      end else begin
        b = ref_mem[s[7:0]];
        ref_mem[d[7:0]] = b;
        if (op == C_BACK) begin d--; s--; end
        else begin d++; s++; end
        n--; st++;
        if (op == C_ZERO && b == 8'd0) break;
      end
    end
    e.dst = d; e.src = s; e.cnt = 16'(n); e.z = exp_z; e.c = exp_c;
    case (op)
      C_BACK:  e.cost = (st > 3) ? 32'(6 + 3 * (st / 4 + st % 4)) : 32'(2 + 3 * st);
      C_FILL:  e.cost = (u == 2'd0) ? 32'(2 + st / 4 + st % 4)
                      : (u == 2'd1) ? 32'(2 + st / 2 + st % 2) : 32'(2 + st);
      C_CMP:   e.cost = 32'(2 + 4 * (st / 4 + st % 4));
      default: e.cost = 32'(2 + 3 * (st / 4 + st % 4));
    endcase
  endtask

  task automatic mem_cmp(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk({tag, " memory image mismatches"}, 32'(bad), 32'd0);
  endtask

  task automatic poke(input int a, input logic [7:0] v);
    mem[a] = v;
    ref_mem[a] = v;
  endtask

  // Driver; poke_start pulses a second start while busy (R8)
  task automatic run(input logic [2:0] op, input logic [1:0] u, input logic [31:0] d,
                     input logic [31:0] s, input logic [15:0] n, input string tag,
                     input bit poke_start);
    exp_t e;
    int   acc0;
    logic z0, c0;
    z0 = exp_z; c0 = exp_c;
    model(op, u, d, s, n, e);
    if (n != 0) begin
      sb_q.push_back(e);
      tag_q.push_back(tag);
    end
    acc0 = acc_cnt;
    @(negedge clk);
    start = 1'b1; op_i = op; unit_i = u; dst_i = d; src_i = s; cnt_i = n;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk({tag, " busy stays low (R7)"}, 32'(busy_o), 32'd0);
      chk({tag, " no memory access (R7)"}, 32'(acc_cnt - acc0), 32'd0);
      chk({tag, " flags unchanged (R7)"}, {30'd0, flag_z_o, flag_c_o}, {30'd0, z0, c0});
      chk({tag, " count loaded (R7)"}, 32'(cnt_o), 32'd0);
      chk({tag, " dst loaded (R7)"}, dst_o, d);
    end else begin
      chk({tag, " busy after start (R8)"}, 32'(busy_o), 32'd1);
      if (poke_start) begin
        @(negedge clk);
        start = 1'b1; op_i = C_FWD; dst_i = 32'h0; src_i = 32'h0; cnt_i = 16'd1;
        @(negedge clk);
        start = 1'b0;
      end
      while (busy_o) @(negedge clk);
      @(negedge clk);
      chk({tag, " scoreboard drained"}, 32'(sb_q.size()), 32'd0);
    end
    mem_cmp(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v;
      v = 8'(i * 13 + 7);
      if (v == 8'd0) v = 8'd1;
      mem[i] = v;
      ref_mem[i] = v;
    end
    repeat (3) @(negedge clk);
    chk("R8 reset busy", 32'(busy_o), 32'd0);
    chk("R8 reset no request", 32'(mem_req_o), 32'd0);
    chk("R6 reset flags", {30'd0, flag_z_o, flag_c_o}, 32'd0);
    chk("R7 reset count", 32'(cnt_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(C_FWD,  2'd0, 32'h40, 32'h10, 16'd6, "R1 forward copy", 1'b0);
    run(C_BACK, 2'd0, 32'h5F, 32'h1F, 16'd5, "R2 backward copy long", 1'b0);
    run(C_BACK, 2'd0, 32'h6F, 32'h2F, 16'd2, "R2 backward copy short", 1'b0);
    poke(8'h83, 8'h00);
    run(C_ZERO, 2'd0, 32'h90, 32'h80, 16'd10, "R3 copy ends after zero byte", 1'b0);
    run(C_ZERO, 2'd0, 32'hA0, 32'h88, 16'd2, "R3 copy ends on count", 1'b0);
    run(C_FILL, 2'd0, 32'hB0, 32'h123456A5, 16'd5, "R4 byte fill", 1'b0);
    run(C_FILL, 2'd1, 32'hC0, 32'hBEEFC0DE, 16'd3, "R4 halfword fill", 1'b0);
    run(C_FILL, 2'd2, 32'hD0, 32'hCAFEF00D, 16'd2, "R4 word fill", 1'b0);
    run(C_CMP,  2'd0, 32'h40, 32'h10, 16'd4, "R5 equal strings", 1'b0);
    poke(8'h42, 8'h05);
    poke(8'h12, 8'h50);
    run(C_CMP,  2'd0, 32'h40, 32'h10, 16'd6, "R5 mismatch first below", 1'b0);
    poke(8'h43, 8'hF0);
    poke(8'h13, 8'h01);
    run(C_CMP,  2'd0, 32'h43, 32'h13, 16'd3, "R6 mismatch first above", 1'b0);
    run(C_CMP,  2'd0, 32'h40, 32'h10, 16'd0, "R7 zero-count compare", 1'b0);
    poke(8'h46, 8'h00);
    poke(8'h16, 8'h00);
    run(C_CMP,  2'd0, 32'h45, 32'h15, 16'd5, "R5 zero byte ends compare", 1'b0);
    run(C_FWD,  2'd0, 32'h70, 32'h10, 16'd0, "R7 zero-count copy", 1'b0);
    run(C_FILL, 2'd2, 32'hE0, 32'h5A5A0F0F, 16'd4, "R8 start ignored while busy", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule